// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides which commands a serial NOR flash front end may carry out. A SPI shift stage sends it one event per frame, on the clock after chip select rises. The event carries the decoded opcode, the target address, the number of bits clocked in the frame and the first data byte. The block keeps the status byte: the write-enable latch, a busy flag, three block-protect bits and a status-write-disable bit. It also samples the write-protect pin, runs a write-inhibit timer after power-up and tracks deep power-down. From these it decides whether a program, erase or status write may go ahead.

An accepted program or erase raises a one-cycle start pulse to the array sequencer, with a kind code and the target address. The busy flag then stays set until the sequencer returns a done pulse, and the write-enable latch clears at that point. A status write takes effect in one cycle. A rejected command changes no state.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 (bit 7 status-write-disable, bits 4:2 block protect, bit 1 write-enable latch, bit 0 busy), `deep_pd` is 0, `op_start` is 0 and `puw_active` is 1.
- R2: For PUW_CYCLES clocks after reset, `puw_active` is 1 and every status write, program and erase is rejected; latch set (0x06) is still honoured. After the window, `puw_active` is 0.
- R3: A frame whose bit count is zero or not a multiple of 8 is ignored entirely, whatever its opcode.
- R4: Opcode 0x06 sets the latch. While the latch is clear, status write (0x01), program (0x02), sector erase (0x20), block erase (0xD8) and chip erase (0x60 or 0xC7) are rejected. A rejected command leaves the latch as it was and raises neither `op_start` nor busy.
- R5: An accepted program or erase pulses `op_start` for one cycle, one clock after the event. `op_kind` gives 1 for program, 2 for sector erase, 3 for block erase and 4 for chip erase, and `op_addr` gives the target. The busy bit is set from that cycle until the clock after `op_done`, and the latch clears at the same time.
- R6: Opcode 0x04 clears the latch. An accepted status write loads bit 7 and bits 4:2 from the data byte and clears the latch.
- R7: Block-protect code 0 protects nothing and code 7 protects the whole array. A code k from 1 to 6 protects the top 2^(k-1) blocks of 64 KB, or the whole array if that many blocks cover it. A program or erase aimed at a protected address is rejected.
- R8: Chip erase is rejected whenever the block-protect code is non-zero.
- R9: While `wp_n` is low, an accepted status write leaves bit 7 and bits 4:2 unchanged but still clears the latch.
- R10: Opcode 0xB9 enters deep power-down. While in it, every command is ignored except 0xAB, which leaves it.
- R11: While busy, every command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cmd_valid | input | 1 | One-cycle frame-end event |
| cmd_op | input | 8 | Decoded opcode of the frame |
| cmd_addr | input | ADDR_W | Target address of the frame |
| cmd_bits | input | BITCNT_W | Number of bits clocked in the frame |
| cmd_data | input | 8 | First data byte (status write value) |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Array sequencer finished the running operation |
| status_o | output | 8 | Status byte |
| op_start | output | 1 | One-cycle start of a program or erase |
| op_kind | output | 4 | Kind of started operation |
| op_addr | output | ADDR_W | Address of started operation |
| deep_pd | output | 1 | Deep power-down state |
| puw_active | output | 1 | Power-up write-inhibit window open |

## Verification
Program commands are aimed at the address just below and the address exactly at the lowest protected address for each protect code. This separates an off-by-one block boundary from a wrong doubling step. The same command is replayed with the latch clear, inside the inhibit window, with a misaligned bit count, while busy and in deep power-down. Each condition must block it on its own, so a gate that ignores any single condition is exposed. Status writes are repeated with the protect pin low and high, which shows that the pin masks only the protect fields and leaves latch clearing intact.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_SE   = 8'h20;
    localparam logic [7:0] OPC_BE   = 8'hD8;
    localparam logic [7:0] OPC_CE_A = 8'h60;
    localparam logic [7:0] OPC_CE_B = 8'hC7;
    localparam logic [7:0] OPC_DP   = 8'hB9;
    localparam logic [7:0] OPC_WAKE = 8'hAB;

    typedef enum logic [3:0] {
        K_NONE = 4'd0,
        K_PP   = 4'd1,
        K_SE   = 4'd2,
        K_BE   = 4'd3,
        K_CE   = 4'd4,
        K_WREN = 4'd5,
        K_WRDI = 4'd6,
        K_WRSR = 4'd7,
        K_DP   = 4'd8,
        K_WAKE = 4'd9,
        K_READ = 4'd10
    } cmd_kind_e;

    typedef struct packed {
        logic      set_wel;
        logic      clr_wel;
        logic      wr_sr;
        logic      start;
        logic      enter_dp;
        logic      exit_dp;
        cmd_kind_e kind;
    } gate_t;

    typedef struct packed {
        logic       srwd;
        logic [2:0] bp;
        logic       wel;
        logic       wip;
        logic       dp;
    } sr_t;

    function automatic cmd_kind_e decode_op(input logic [7:0] op);
        case (op)
            OPC_WREN:           return K_WREN;
            OPC_WRDI:           return K_WRDI;
            OPC_WRSR:           return K_WRSR;
            OPC_PP:             return K_PP;
            OPC_SE:             return K_SE;
            OPC_BE:             return K_BE;
            OPC_CE_A, OPC_CE_B: return K_CE;
            OPC_DP:             return K_DP;
            OPC_WAKE:           return K_WAKE;
            default:            return K_READ;
        endcase
    endfunction

    // Number of locked blocks counted down from the top of the array.
    function automatic int unsigned locked_span(input logic [2:0] bp,
                                                input int unsigned nblk);
        int unsigned span;
        if (bp == 3'd0)      span = 0;
        else if (bp == 3'd7) span = nblk;
        else                 span = 32'd1 << (bp - 3'd1);
        return (span > nblk) ? nblk : span;
    endfunction

    function automatic logic blk_locked(input logic [2:0] bp,
                                        input int unsigned blk,
                                        input int unsigned nblk);
        int unsigned span;
        span = locked_span(bp, nblk);
        return (span != 0) && (blk >= nblk - span);
    endfunction

endpackage

// File: rtl/wp_puw_timer.sv
module wp_puw_timer #(
    parameter int unsigned PUW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    output logic active
);
    localparam int unsigned CW = $clog2(PUW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(PUW_CYCLES);

    logic [CW-1:0] cnt;

    assign active = (cnt != LIMIT);

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (active) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
    import flash_wp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned BLK_AW   = 16,
    parameter int unsigned BITCNT_W = 12
) (
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [BITCNT_W-1:0] cmd_bits,
    input  sr_t                 sr,
    input  logic                puw,
    output gate_t               g
);
    localparam int unsigned NBLK = 1 << (ADDR_W - BLK_AW);

    cmd_kind_e   kind;
    logic        aligned;
    logic        may_write;
    logic        locked;
    int unsigned blk;

    always_comb begin
        kind      = decode_op(cmd_op);
        aligned   = (cmd_bits[2:0] == 3'd0) && (cmd_bits != '0);
        may_write = sr.wel && !puw;
        blk       = 32'(cmd_addr[ADDR_W-1:BLK_AW]);
        locked    = blk_locked(sr.bp, blk, NBLK);

        g      = '0;
        g.kind = kind;
        if (cmd_valid && aligned) begin
            if (sr.dp) begin
                g.exit_dp = (kind == K_WAKE);
            end else if (!sr.wip) begin
                case (kind)
                    K_WREN: g.set_wel  = 1'b1;
                    K_WRDI: g.clr_wel  = 1'b1;
                    K_DP:   g.enter_dp = 1'b1;
                    K_WRSR: begin
                        g.wr_sr   = may_write;
                        g.clr_wel = may_write;
                    end
                    K_PP, K_SE, K_BE: g.start = may_write && !locked;
                    K_CE:   g.start = may_write && (sr.bp == 3'd0);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import flash_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  gate_t      g,
    input  logic [7:0] wr_data,
    input  logic       wp_n,
    input  logic       op_done,
    output sr_t        sr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            if (g.set_wel)              sr.wel <= 1'b1;
            else if (g.clr_wel)         sr.wel <= 1'b0;
            else if (sr.wip && op_done) sr.wel <= 1'b0;

            if (g.start)                sr.wip <= 1'b1;
            else if (op_done)           sr.wip <= 1'b0;

            if (g.wr_sr && wp_n) begin
                sr.srwd <= wr_data[7];
                sr.bp   <= wr_data[4:2];
            end

            if (g.enter_dp)             sr.dp <= 1'b1;
            else if (g.exit_dp)         sr.dp <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned BLK_AW     = 16,
    parameter int unsigned BITCNT_W   = 12,
    parameter int unsigned PUW_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [BITCNT_W-1:0] cmd_bits,
    input  logic [7:0]          cmd_data,
    input  logic                wp_n,
    input  logic                op_done,
    output logic [7:0]          status_o,
    output logic                op_start,
    output logic [3:0]          op_kind,
    output logic [ADDR_W-1:0]   op_addr,
    output logic                deep_pd,
    output logic                puw_active
);
    gate_t g;
    sr_t   sr;
    logic  puw;

    wp_puw_timer #(.PUW_CYCLES(PUW_CYCLES)) u_puw (
        .clk    (clk),
        .rst    (rst),
        .active (puw)
    );

    wp_cmd_gate #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .BITCNT_W(BITCNT_W)) u_gate (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_bits  (cmd_bits),
        .sr        (sr),
        .puw       (puw),
        .g         (g)
    );

    wp_status_reg u_sr (
        .clk     (clk),
        .rst     (rst),
        .g       (g),
        .wr_data (cmd_data),
        .wp_n    (wp_n),
        .op_done (op_done),
        .sr      (sr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_start <= 1'b0;
            op_kind  <= K_NONE;
            op_addr  <= '0;
        end else begin
            op_start <= g.start;
            op_kind  <= g.start ? g.kind : K_NONE;
            if (g.start) op_addr <= cmd_addr;
        end
    end

    assign status_o   = {sr.srwd, 2'b00, sr.bp, sr.wel, sr.wip};
    assign deep_pd    = sr.dp;
    assign puw_active = puw;
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       wp_n,
    input logic [7:0] status_o,
    input logic       op_start,
    input logic [3:0] op_kind,
    input logic       deep_pd,
    input logic       puw_active
);
    // R4
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $past(status_o[1]));

    // R2
    start_after_puw_chk: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !$past(puw_active));

    // R11
    start_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !$past(status_o[0]));

    // R8
    ce_bp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == 4'd4) |-> ($past(status_o[4:2]) == 3'd0));

    // R9
    wp_pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wp_n |=> $stable({status_o[7], status_o[4:2]}));

    // R10
    dp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (deep_pd && !(cmd_valid && cmd_op == 8'hAB)) |=> (deep_pd && $stable(status_o)));

    // R5
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        op_start |-> status_o[0]);
endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .wp_n       (wp_n),
    .status_o   (status_o),
    .op_start   (op_start),
    .op_kind    (op_kind),
    .deep_pd    (deep_pd),
    .puw_active (puw_active)
);

// File: tb/sim_flash_wp_ctrl.sv
`timescale 1ns/1ps
module sim_flash_wp_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [19:0] cmd_addr = '0;
    logic [11:0] cmd_bits = '0;
    logic [7:0]  cmd_data = 8'h00;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic [7:0]  status_o;
    logic        op_start;
    logic [3:0]  op_kind;
    logic [19:0] op_addr;
    logic        deep_pd;
    logic        puw_active;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic        l_start;
    logic [3:0]  l_kind;
    logic [19:0] l_addr;

    always #2 clk = ~clk;

    flash_wp_ctrl u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bits(cmd_bits), .cmd_data(cmd_data),
        .wp_n(wp_n), .op_done(op_done), .status_o(status_o),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .deep_pd(deep_pd), .puw_active(puw_active)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [19:0] a,
                        input logic [11:0] nb, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_bits = nb; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        l_start = op_start; l_kind = op_kind; l_addr = op_addr;
    endtask

    task automatic finish_op();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic set_bp(input logic [2:0] bp);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h01, '0, 12'd16, {3'b000, bp, 2'b00});
    endtask

    task automatic t_reset();
        chk(status_o == 8'h00, "R1", "status", status_o, 8'h00);
        chk(!deep_pd && !op_start, "R1", "dp/start", {deep_pd, op_start}, 0);
        chk(puw_active, "R1", "puw_active", puw_active, 1);
    endtask

    task automatic t_puw();
        send(8'h06, '0, 12'd8, 8'h00);
        chk(status_o[1], "R2", "WREN in window", status_o, 8'h02);
        send(8'h02, 20'h00100, 12'd32, 8'h00);
        chk(!l_start && status_o == 8'h02, "R2", "PP in window", {l_start, status_o}, 8'h02);
        send(8'h01, '0, 12'd16, 8'h0C);
        chk(status_o == 8'h02, "R2", "WRSR in window", status_o, 8'h02);
        chk(puw_active, "R2", "window open", puw_active, 1);
        repeat (70) @(negedge clk);
        chk(!puw_active, "R2", "window closed", puw_active, 0);
        send(8'h02, 20'h00100, 12'd32, 8'h00);
        chk(l_start && l_kind == 4'd1 && l_addr == 20'h00100, "R5", "PP after window",
            {l_start, l_kind, l_addr}, {1'b1, 4'd1, 20'h00100});
        finish_op();
        chk(status_o == 8'h00, "R5", "done clears busy+wel", status_o, 8'h00);
    endtask

    task automatic t_align();
        send(8'h06, '0, 12'd7, 8'h00);
        chk(!status_o[1], "R3", "WREN 7 bits", status_o, 8'h00);
        send(8'h06, '0, 12'd0, 8'h00);
        chk(!status_o[1], "R3", "WREN 0 bits", status_o, 8'h00);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h02, 20'h00200, 12'd33, 8'h00);
        chk(!l_start && status_o == 8'h02, "R3", "PP 33 bits", {l_start, status_o}, 8'h02);
        send(8'h04, '0, 12'd12, 8'h00);
        chk(status_o[1], "R3", "WRDI 12 bits", status_o, 8'h02);
        send(8'h04, '0, 12'd8, 8'h00);
        chk(!status_o[1], "R6", "WRDI clears", status_o, 8'h00);
    endtask

    task automatic t_wel_gate();
        send(8'h20, 20'h01000, 12'd32, 8'h00);
        chk(!l_start && status_o == 8'h00, "R4", "SE without WEL", {l_start, status_o}, 0);
        send(8'h01, '0, 12'd16, 8'h1C);
        chk(status_o == 8'h00, "R4", "WRSR without WEL", status_o, 0);
        send(8'hC7, '0, 12'd8, 8'h00);
        chk(!l_start, "R4", "CE without WEL", l_start, 0);
    endtask

    task automatic t_program();
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'hD8, 20'h30000, 12'd32, 8'h00);
        chk(l_start && l_kind == 4'd3 && l_addr == 20'h30000, "R5", "BE start",
            {l_start, l_kind, l_addr}, {1'b1, 4'd3, 20'h30000});
        chk(status_o == 8'h03, "R5", "busy+wel during op", status_o, 8'h03);
        @(negedge clk);
        chk(!op_start, "R5", "start one cycle", op_start, 0);
        finish_op();
        chk(status_o == 8'h00, "R5", "BE done", status_o, 8'h00);
    endtask

    task automatic t_busy();
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h20, 20'h10000, 12'd32, 8'h00);
        chk(l_start && l_kind == 4'd2, "R5", "SE start", {l_start, l_kind}, {1'b1, 4'd2});
        send(8'h04, '0, 12'd8, 8'h00);
        chk(status_o == 8'h03, "R11", "WRDI while busy", status_o, 8'h03);
        send(8'h02, 20'h00000, 12'd32, 8'h00);
        chk(!l_start, "R11", "PP while busy", l_start, 0);
        send(8'hB9, '0, 12'd8, 8'h00);
        chk(!deep_pd, "R11", "DP while busy", deep_pd, 0);
        finish_op();
        chk(status_o == 8'h00, "R11", "after done", status_o, 8'h00);
    endtask

    task automatic t_wrsr();
        set_bp(3'd5);
        chk(status_o == 8'h14, "R6", "WRSR bp=5 wel cleared", status_o, 8'h14);
        set_bp(3'd0);
        chk(status_o == 8'h00, "R6", "WRSR bp=0", status_o, 8'h00);
    endtask

    task automatic t_bp_map();
        for (int bp = 1; bp <= 4; bp++) begin
            logic [31:0] thr;
            thr = 32'h100000 - (32'h10000 << (bp - 1));
            set_bp(3'(bp));
            send(8'h06, '0, 12'd8, 8'h00);
            send(8'h02, 20'(thr - 1), 12'd32, 8'h00);
            chk(l_start, "R7", $sformatf("bp=%0d below edge", bp), l_start, 1);
            finish_op();
            send(8'h06, '0, 12'd8, 8'h00);
            send(8'h02, 20'(thr), 12'd32, 8'h00);
            chk(!l_start && status_o[1] && !status_o[0], "R7",
                $sformatf("bp=%0d at edge rejected, wel kept", bp),
                {l_start, status_o}, {1'b0, 8'(bp << 2) | 8'h02});
            send(8'h04, '0, 12'd8, 8'h00);
        end
        set_bp(3'd5);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h20, 20'h00000, 12'd32, 8'h00);
        chk(!l_start, "R7", "bp=5 whole array", l_start, 0);
        send(8'h04, '0, 12'd8, 8'h00);
        set_bp(3'd7);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h02, 20'h00000, 12'd32, 8'h00);
        chk(!l_start, "R7", "bp=7 whole array", l_start, 0);
        send(8'h04, '0, 12'd8, 8'h00);
        set_bp(3'd0);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h02, 20'hFFFFF, 12'd32, 8'h00);
        chk(l_start && l_addr == 20'hFFFFF, "R7", "bp=0 top addr", {l_start, l_addr}, {1'b1, 20'hFFFFF});
        finish_op();
    endtask

    task automatic t_ce_bp();
        set_bp(3'd1);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h60, '0, 12'd8, 8'h00);
        chk(!l_start && status_o == 8'h06, "R8", "CE with bp=1", {l_start, status_o}, 8'h06);
        send(8'h04, '0, 12'd8, 8'h00);
        set_bp(3'd0);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'hC7, '0, 12'd8, 8'h00);
        chk(l_start && l_kind == 4'd4, "R8", "CE with bp=0", {l_start, l_kind}, {1'b1, 4'd4});
        finish_op();
    endtask

    task automatic t_wp_pin();
        wp_n = 1'b0;
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h01, '0, 12'd16, 8'h9C);
        chk(status_o == 8'h00, "R9", "WRSR with wp low", status_o, 8'h00);
        wp_n = 1'b1;
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h01, '0, 12'd16, 8'h9C);
        chk(status_o == 8'h9C, "R9", "WRSR with wp high", status_o, 8'h9C);
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'h01, '0, 12'd16, 8'h00);
        chk(status_o == 8'h00, "R6", "WRSR restore", status_o, 8'h00);
    endtask

    task automatic t_deep_pd();
        send(8'h06, '0, 12'd8, 8'h00);
        send(8'hB9, '0, 12'd8, 8'h00);
        chk(deep_pd, "R10", "enter", deep_pd, 1);
        send(8'h04, '0, 12'd8, 8'h00);
        chk(status_o == 8'h02, "R10", "WRDI ignored", status_o, 8'h02);
        send(8'h02, 20'h00000, 12'd32, 8'h00);
        chk(!l_start, "R10", "PP ignored", l_start, 0);
        send(8'hAB, '0, 12'd9, 8'h00);
        chk(deep_pd, "R10", "misaligned wake ignored", deep_pd, 1);
        send(8'hAB, '0, 12'd8, 8'h00);
        chk(!deep_pd && status_o == 8'h02, "R10", "wake", {deep_pd, status_o}, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_puw();
        t_align();
        t_wel_gate();
        t_program();
        t_busy();
        t_wrsr();
        t_bp_map();
        t_ce_bp();
        t_wp_pin();
        t_deep_pd();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule